// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block takes synthesizer configuration from a host over three wires: a serial data line, a serial clock and a load strobe. Each rising edge of the serial clock pushes one bit into a 23-bit shift register, most significant bit first. When the load strobe rises, the assembled word is copied into one of four holding registers. Two channels each have a reference register and a program register, and the two lowest bits of the word pick the register.

The held values drive the dividers and mode controls of a dual synthesizer as parallel outputs. The reference register of each channel supplies a 14-bit reference divisor, a charge-pump current select and a two-bit monitor-source select. The program register of each channel supplies an 11-bit main divisor, a 7-bit swallow count, the prescaler modulus select, the phase-detector polarity and the shared-pin routing select. All three serial lines are asynchronous to the system clock. Each is brought into the system clock domain through a two-flop synchronizer, and edges are found by oversampling.

Top module: `cfg3w_top`

## Requirements
- R1: Each rising edge of the serial clock, seen while the load strobe is low, shifts the data line into bit 0 of the 23-bit shift register and moves every bit up by one, so the first bit sent ends in bit 22.
- R2: A rising edge of the load strobe copies the word into the register chosen by bit 0 (channel: 0 = channel 1, 1 = channel 2) and bit 1 (kind: 0 = reference, 1 = program). The other three registers keep their values.
- R3: A reference word gives bits 17:4 as the reference divisor (bit 4 is the LSB) on ref_div_o, bit 18 as the charge-pump select on cp_hi_o (1 = high current), and bits 2 and 3 as mon_src_o = {bit 3, bit 2}. Bits 22:19 have no effect on any output.
- R4: A program word gives bit 2 on lds_o (1 = phase monitor on the shared pin, 0 = lock signal), bit 3 on pre_sel_o, bit 4 on phase_inv_o, bits 11:5 as the swallow count on swallow_o, and bits 22:12 as the main divisor on prog_div_o. The LSB of each field is the lower bit number.
- R5: After a synchronous reset, every register output is zero and no write strobe is active.
- R6: Each load raises exactly one bit of wr_stb_o for exactly one cycle, at index {bit 1, bit 0} of the word (0 ch1 reference, 1 ch2 reference, 2 ch1 program, 3 ch2 program). Two bits are never high together.
- R7: Serial clock edges that arrive while the load strobe is high do not change the shift register.
- R8: When more than 23 bits are clocked in before a load, only the last 23 bits count.
- R9: Register outputs hold their values in every cycle without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock |
| ser_dat_i | input | 1 | Asynchronous serial data |
| ser_le_i | input | 1 | Asynchronous load strobe |
| ref_div_o | output | 2x14 | Reference divisor per channel |
| cp_hi_o | output | 2 | Charge-pump high-current select per channel |
| mon_src_o | output | 2x2 | Monitor-source select per channel |
| prog_div_o | output | 2x11 | Main divisor per channel |
| swallow_o | output | 2x7 | Swallow count per channel |
| pre_sel_o | output | 2 | Prescaler modulus select per channel |
| phase_inv_o | output | 2 | Phase-detector polarity per channel |
| lds_o | output | 2 | Shared-pin routing select per channel |
| wr_stb_o | output | 4 | One-cycle update pulse per register |

## Verification
The assertions assume that each serial line holds every level for at least several system clock cycles, so the synchronizers see each edge once. They also assume that the data line is steady around each serial clock rise. The stimulus holds every data, clock and strobe level for two or more system cycles. Data changes only while the serial clock is low. The strobe rises only after the last clock fall. The one deliberate violation is serial clock pulses sent while the strobe is high, which checks that those edges are ignored.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
    localparam int WORD_W = 23;
    localparam int CH_N   = 2;
    localparam int REF_W  = 14;
    localparam int SWL_W  = 7;
    localparam int PRG_W  = 11;
    localparam int SPARE_W = WORD_W - REF_W - 5;
    localparam int DEST_N = 4;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic               cp_hi;
        logic [REF_W-1:0]   ref_div;
        logic               t_kind;
        logic               t_chan;
        logic               kind;
        logic               chan;
    } ref_word_t;

    typedef struct packed {
        logic [PRG_W-1:0] n;
        logic [SWL_W-1:0] a;
        logic             inv;
        logic             pre;
        logic             lds;
        logic             kind;
        logic             chan;
    } prog_word_t;

    typedef struct packed {
        logic [REF_W-1:0] ref_div;
        logic             cp_hi;
        logic [1:0]       mon_src;
    } ref_cfg_t;

    typedef struct packed {
        logic [PRG_W-1:0] n;
        logic [SWL_W-1:0] a;
        logic             inv;
        logic             pre;
        logic             lds;
    } prog_cfg_t;

    typedef enum logic [1:0] {
        DST_REF_CH1 = 2'd0,
        DST_REF_CH2 = 2'd1,
        DST_PRG_CH1 = 2'd2,
        DST_PRG_CH2 = 2'd3
    } dest_e;

    function automatic ref_cfg_t to_ref_cfg(input logic [WORD_W-1:0] w);
        ref_word_t rw;
        ref_cfg_t  c;
        rw = ref_word_t'(w);
        c.ref_div = rw.ref_div;
        c.cp_hi   = rw.cp_hi;
        c.mon_src = {rw.t_kind, rw.t_chan};
        return c;
    endfunction

    function automatic prog_cfg_t to_prog_cfg(input logic [WORD_W-1:0] w);
        prog_word_t pw;
        prog_cfg_t  c;
        pw = prog_word_t'(w);
        c.n   = pw.n;
        c.a   = pw.a;
        c.inv = pw.inv;
        c.pre = pw.pre;
        c.lds = pw.lds;
        return c;
    endfunction

    function automatic dest_e dest_of(input logic [WORD_W-1:0] w);
        return dest_e'(w[1:0]);
    endfunction
endpackage

// File: rtl/cfg3w_insync.sv
module cfg3w_insync #(
    parameter int N_LINES = 3,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] raw_i,
    output logic [N_LINES-1:0] lvl_o,
    output logic [N_LINES-1:0] rise_o
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES:0] pipe;

        always_ff @(posedge clk) begin
            if (rst) pipe <= '0;
            else     pipe <= {pipe[STAGES-1:0], raw_i[g]};
        end

        assign lvl_o[g]  = pipe[STAGES-1];
        assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];

        AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
            rise_o[g] |=> !rise_o[g]); // R1
    end
endmodule

// File: rtl/cfg3w_shreg.sv
module cfg3w_shreg #(
    parameter int W = cfg3w_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         hold_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)                     sreg <= '0;
        else if (shift_i && !hold_i) sreg <= {sreg[W-2:0], bit_i};
    end

    assign word_o = sreg;

    AST_HOLD_WHILE_LE: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> $stable(word_o)); // R7

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
        (shift_i && !hold_i) |=> (word_o[W-1:1] == $past(word_o[W-2:0]))); // R1
endmodule

// File: rtl/cfg3w_latches.sv
module cfg3w_latches
    import cfg3w_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NC = CH_N,
    parameter int ND = DEST_N
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [W-1:0]   word_i,
    output ref_cfg_t       ref_q  [NC],
    output prog_cfg_t      prog_q [NC],
    output logic [ND-1:0]  stb_o
);
    dest_e dst;
    assign dst = dest_of(word_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_o <= '0;
            for (int c = 0; c < NC; c++) begin
                ref_q[c]  <= '0;
                prog_q[c] <= '0;
            end
        end else begin
            stb_o <= '0;
            if (load_i) begin
                stb_o[dst] <= 1'b1;
                for (int c = 0; c < NC; c++) begin
                    if (word_i[0] == c[0]) begin
                        if (word_i[1]) prog_q[c] <= to_prog_cfg(word_i);
                        else           ref_q[c]  <= to_ref_cfg(word_i);
                    end
                end
            end
        end
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb_o)); // R6

    AST_LOAD_STROBES: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (stb_o != '0)); // R6

    for (genvar c = 0; c < NC; c++) begin : g_hold
        AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
            !load_i |=> ($stable(ref_q[c]) && $stable(prog_q[c]))); // R9
    end
endmodule

// File: rtl/cfg3w_top.sv
module cfg3w_top
    import cfg3w_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ser_clk_i,
    input  logic                        ser_dat_i,
    input  logic                        ser_le_i,
    output logic [CH_N-1:0][REF_W-1:0]  ref_div_o,
    output logic [CH_N-1:0]             cp_hi_o,
    output logic [CH_N-1:0][1:0]        mon_src_o,
    output logic [CH_N-1:0][PRG_W-1:0]  prog_div_o,
    output logic [CH_N-1:0][SWL_W-1:0]  swallow_o,
    output logic [CH_N-1:0]             pre_sel_o,
    output logic [CH_N-1:0]             phase_inv_o,
    output logic [CH_N-1:0]             lds_o,
    output logic [DEST_N-1:0]           wr_stb_o
);
    localparam int LINES = 3;
    localparam int L_CLK = 0;
    localparam int L_DAT = 1;
    localparam int L_LE  = 2;

    logic [LINES-1:0] lvl, rise;
    logic [WORD_W-1:0] word;
    ref_cfg_t  ref_q  [CH_N];
    prog_cfg_t prog_q [CH_N];

    cfg3w_insync #(.N_LINES(LINES), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({ser_le_i, ser_dat_i, ser_clk_i}),
        .lvl_o  (lvl),
        .rise_o (rise)
    );

    cfg3w_shreg #(.W(WORD_W)) u_shreg (
        .clk     (clk),
        .rst     (rst),
        .shift_i (rise[L_CLK]),
        .hold_i  (lvl[L_LE]),
        .bit_i   (lvl[L_DAT]),
        .word_o  (word)
    );

    cfg3w_latches #(.W(WORD_W), .NC(CH_N), .ND(DEST_N)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .load_i (rise[L_LE]),
        .word_i (word),
        .ref_q  (ref_q),
        .prog_q (prog_q),
        .stb_o  (wr_stb_o)
    );

    for (genvar c = 0; c < CH_N; c++) begin : g_out
        assign ref_div_o[c]   = ref_q[c].ref_div;
        assign cp_hi_o[c]     = ref_q[c].cp_hi;
        assign mon_src_o[c]   = ref_q[c].mon_src;
        assign prog_div_o[c]  = prog_q[c].n;
        assign swallow_o[c]   = prog_q[c].a;
        assign pre_sel_o[c]   = prog_q[c].pre;
        assign phase_inv_o[c] = prog_q[c].inv;
        assign lds_o[c]       = prog_q[c].lds;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (wr_stb_o == '0 && ref_div_o == '0 && prog_div_o == '0)); // R5
endmodule

// File: tb/sim_cfg3w_top.sv
module sim_cfg3w_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic [1:0][13:0] ref_div;
    logic [1:0]       cp_hi;
    logic [1:0][1:0]  mon_src;
    logic [1:0][10:0] prog_div;
    logic [1:0][6:0]  swallow;
    logic [1:0]       pre_sel, phase_inv, lds;
    logic [3:0]       wr_stb;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [13:0] e_ref [2];
    logic        e_cp  [2];
    logic [1:0]  e_mon [2];
    logic [10:0] e_n   [2];
    logic [6:0]  e_a   [2];
    logic        e_pre [2], e_inv [2], e_lds [2];
    int          e_stb [4];
    int          seen_stb [4];
    int          multi_hot = 0;

    always #10 clk = ~clk;

    cfg3w_top u0 (
        .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
        .ref_div_o(ref_div), .cp_hi_o(cp_hi), .mon_src_o(mon_src),
        .prog_div_o(prog_div), .swallow_o(swallow), .pre_sel_o(pre_sel),
        .phase_inv_o(phase_inv), .lds_o(lds), .wr_stb_o(wr_stb)
    );

    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 4; i++) if (wr_stb[i]) seen_stb[i]++;
            if ($countones(wr_stb) > 1) multi_hot++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = v[i];
            wait_clk(3);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
            wait_clk(2);
        end
    endtask

    function automatic void model_load(input logic [22:0] w);
        int c;
        c = w[0];
        e_stb[w[1:0]]++;
        if (!w[1]) begin
            e_ref[c] = w[17:4];
            e_cp[c]  = w[18];
            e_mon[c] = w[3:2];
        end else begin
            e_lds[c] = w[2];
            e_pre[c] = w[3];
            e_inv[c] = w[4];
            e_a[c]   = w[11:5];
            e_n[c]   = w[22:12];
        end
    endfunction

    task automatic pulse_le(input int noise);
        sle = 1'b1;
        wait_clk(4);
        for (int i = 0; i < noise; i++) begin
            sdat = 1'b1;
            wait_clk(2);
            sclk = 1'b1;
            wait_clk(3);
            sclk = 1'b0;
            wait_clk(2);
        end
        wait_clk(4);
        sle = 1'b0;
        wait_clk(4);
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 2; c++) begin
            chk({tag, " R3 ref_div"},   ref_div[c],  e_ref[c]);
            chk({tag, " R3 cp_hi"},     cp_hi[c],    e_cp[c]);
            chk({tag, " R3 mon_src"},   mon_src[c],  e_mon[c]);
            chk({tag, " R4 prog_div"},  prog_div[c], e_n[c]);
            chk({tag, " R4 swallow"},   swallow[c],  e_a[c]);
            chk({tag, " R4 bits"},      {pre_sel[c], phase_inv[c], lds[c]},
                                         {e_pre[c], e_inv[c], e_lds[c]});
        end
        for (int i = 0; i < 4; i++) chk({tag, " R6 strobe count"}, seen_stb[i], e_stb[i]);
    endtask

    task automatic send_word(input logic [22:0] w, input string tag);
        shift_bits(w, 23);
        pulse_le(0);
        model_load(w);
        check_all(tag);
    endtask

    initial begin
        for (int c = 0; c < 2; c++) begin
            e_ref[c] = '0; e_cp[c] = 0; e_mon[c] = '0; e_n[c] = '0; e_a[c] = '0;
            e_pre[c] = 0; e_inv[c] = 0; e_lds[c] = 0;
        end
        for (int i = 0; i < 4; i++) begin e_stb[i] = 0; seen_stb[i] = 0; end
        void'($urandom(32'd1234));
        wait_clk(5);
        chk("R5 strobe in reset", wr_stb, 4'h0);
        rst = 1'b0;
        wait_clk(3);
        check_all("R5 reset");

        // directed: each destination, R1 R2 R3 R4
        send_word({4'b1111, 1'b1, 14'h3FFF, 2'b10, 2'b00}, "R2 ch1 ref max");
        send_word({4'b0101, 1'b0, 14'd3,    2'b01, 2'b01}, "R2 ch2 ref min");
        send_word({11'd2047, 7'd127, 3'b101, 2'b10}, "R2 ch1 prog max");
        send_word({11'd3, 7'd0, 3'b010, 2'b11}, "R1 ch2 prog");

        // R3: spare bits ignored
        send_word({4'b0000, 1'b1, 14'h3FFF, 2'b10, 2'b00}, "R3 spare bits");

        // R7: clock edges while strobe high ignored; a reload gives the same word
        shift_bits({11'd1000, 7'd55, 3'b011, 2'b10}, 23);
        pulse_le(5);
        model_load({11'd1000, 7'd55, 3'b011, 2'b10});
        check_all("R7 first");
        pulse_le(0);
        model_load({11'd1000, 7'd55, 3'b011, 2'b10});
        check_all("R7 reload unchanged");

        // R8: overlong frame keeps last 23 bits
        shift_bits(32'h1F, 5);
        send_word({4'b0011, 1'b0, 14'd9999, 2'b11, 2'b01}, "R8 overlong");

        // random words, R2 R9
        for (int k = 0; k < 40; k++) begin
            logic [22:0] w;
            w = 23'($urandom);
            send_word(w, "R2 R9 random");
        end

        chk("R6 multi-hot strobes", multi_hot, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule